// File: doc/BRIEF.md
# Serial Flash Command Phase Sequencer

This block is a register-programmed engine that runs one serial NOR flash transaction per software trigger. Software loads an opcode, an address, byte counts, a chip-select number and chip-select timing. It fills a small byte buffer when data is to be sent, then writes an operation word. That word holds one enable bit per phase and a start bit. The engine drives a single-lane SPI link (mode 0, most significant bit first). The phases run in a fixed order: opcode, address, dummy, write data, read data. A phase whose enable is clear, or whose length is zero, is skipped.

Bytes received during a read phase go back into the same buffer, starting at index 0. Chip select is held low for a programmed setup time before the first clock and a programmed hold time after the last clock. It then stays high for a programmed minimum deselect time before the operation counts as finished. At that point a sticky done flag is set, and it is also brought out on a pin. Software clears the flag through a clear register.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset every chip select is high, the serial clock is low, `op_done` is 0 and the status register (word 0x02) reads 0.
- R2: Enabled phases run in the order opcode, address, dummy, write data, read data. Phase enables sit in the operation word (word 0x08): bit 7 opcode, bit 6 address, bit 8 dummy, bit 5 write data, bit 2 read data, bit 1 read status. A disabled phase sends nothing, even when its count is non-zero.
- R3: Each byte goes out most significant bit first. The serial clock idles low, and the data line changes only while the clock is low (SPI mode 0).
- R4: The address phase sends the address register (word 0x05) most significant byte first. It sends 4 bytes when bit 0 of the mode register (word 0x00) is 1, and the low 3 bytes when that bit is 0.
- R5: The dummy phase sends as many 0x00 bytes as bits 3:0 of the config register (word 0x06) give.
- R6: The write-data phase sends buffer bytes (words 0x40 and up, low byte) from index 0. The byte count is bits 13:0 of word 0x07. The opcode is bits 7:0 of word 0x04.
- R7: A read phase, enabled by bit 2 or bit 1, clocks in the count from word 0x07 and stores byte k in buffer index k. The input line is sampled at the rising serial clock edge, and 0x00 is sent meanwhile.
- R8: Bit 11 of the config register selects which chip select goes low. At most one chip select is ever low.
- R9: With setup time S (timing register word 0x01, bits 7:4), chip select is low for exactly S+2 clock cycles before the serial clock first goes high.
- R10: With hold time H (bits 11:8), chip select stays low for exactly H+1 cycles after the last falling serial clock edge.
- R11: With deselect time D (bits 3:0), chip select stays high for exactly D+1 cycles before `op_done` rises.
- R12: The done flag (status bit 0 and `op_done`) stays set until a write with bit 0 set reaches the clear register (word 0x03). A write with bit 0 clear leaves it set.
- R13: The start bit (operation word bit 0) clears itself. While an operation runs, it reads back as 1. A write to the operation word during an operation is ignored, and the enables stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| op_done | output | 1 | Sticky operation-done flag |
| flash_cs_n | output | NUM_CS | Active-low chip selects |
| flash_sclk | output | 1 | Serial clock |
| flash_mosi | output | 1 | Serial data to flash |
| flash_miso | input | 1 | Serial data from flash |

## Verification
Some rules hold on every cycle, and the assertions check those:
- at most one chip select is low;
- the serial clock only pulses inside a frame;
- the data line is steady across each rising clock edge;
- the done flag is sticky until cleared, and clears on request;
- a write to the operation word during a busy operation leaves the enables alone.

The rest depends on the programmed values, and only the bench scenarios can show it. This covers the byte stream itself, in phase order, with phases skipped and with 3- versus 4-byte addressing. It also covers the bytes read back into the buffer, the exact setup, hold and deselect cycle counts, and the choice of chip select.

// File: rtl/spi_flash_seq_pkg.sv
package spi_flash_seq_pkg;

  localparam logic [7:0] RA_MODE   = 8'h00;
  localparam logic [7:0] RA_TIMING = 8'h01;
  localparam logic [7:0] RA_STATUS = 8'h02;
  localparam logic [7:0] RA_CLEAR  = 8'h03;
  localparam logic [7:0] RA_OPCODE = 8'h04;
  localparam logic [7:0] RA_ADDR   = 8'h05;
  localparam logic [7:0] RA_OPCFG  = 8'h06;
  localparam logic [7:0] RA_DCOUNT = 8'h07;
  localparam logic [7:0] RA_OP     = 8'h08;
  localparam logic [7:0] RA_BUF    = 8'h40;

  localparam int CNT_W = 14;

  // phase codes, in transmit order
  localparam logic [2:0] PH_OP    = 3'd0;
  localparam logic [2:0] PH_ADDR  = 3'd1;
  localparam logic [2:0] PH_DUMMY = 3'd2;
  localparam logic [2:0] PH_WR    = 3'd3;
  localparam logic [2:0] PH_RD    = 3'd4;
  localparam logic [2:0] PH_END   = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD, ST_DESEL
  } seq_state_e;

  typedef struct packed {
    logic [7:0]       opcode;
    logic [31:0]      addr;
    logic             addr4;
    logic [3:0]       dummy_n;
    logic [CNT_W-1:0] dcount;
    logic [3:0]       cs_sel;
    logic             en_op;
    logic             en_addr;
    logic             en_dummy;
    logic             en_wr;
    logic             en_rd;
    logic [3:0]       t_setup;
    logic [3:0]       t_hold;
    logic [3:0]       t_desel;
  } op_cfg_t;

endpackage

// File: rtl/spi_flash_seq_regs.sv
module spi_flash_seq_regs
  import spi_flash_seq_pkg::*;
#(
  parameter int NUM_CS    = 2,
  parameter int BUF_DEPTH = 16,
  localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int BUF_AW   = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              start,
  output op_cfg_t           cfg,
  input  logic              busy,
  input  logic              done_set,
  output logic              done,
  input  logic [BUF_AW-1:0] buf_rd_idx,
  output logic [7:0]        buf_rd_data,
  input  logic              eng_wr,
  input  logic [BUF_AW-1:0] eng_idx,
  input  logic [7:0]        eng_data
);

  localparam logic [7:0] EN_MASK = 8'hF3;  // defined enables in word bits 8:1

  logic             mode_q;
  logic [11:0]      timing_q;
  logic [7:0]       opcode_q;
  logic [31:0]      addr_q;
  logic [CS_W-1:0]  cs_q;
  logic [3:0]       dummy_q;
  logic [CNT_W-1:0] dcount_q;
  logic [7:0]       op_en_q;
  logic             done_q, done_d;
  logic [7:0]       buf_q [BUF_DEPTH];

  logic we_mode, we_timing, we_opcode, we_addr, we_opcfg, we_dcount, we_op, clr;
  logic [7:0] buf_off;
  logic       buf_hit;
  logic [7:0] en_src;

  always_comb begin
    we_mode   = bus_wr && (bus_addr == RA_MODE);
    we_timing = bus_wr && (bus_addr == RA_TIMING);
    we_opcode = bus_wr && (bus_addr == RA_OPCODE);
    we_addr   = bus_wr && (bus_addr == RA_ADDR);
    we_opcfg  = bus_wr && (bus_addr == RA_OPCFG);
    we_dcount = bus_wr && (bus_addr == RA_DCOUNT);
    we_op     = bus_wr && (bus_addr == RA_OP) && !busy;
    clr       = bus_wr && (bus_addr == RA_CLEAR) && bus_wdata[0];
    start     = we_op && bus_wdata[0];
    buf_off   = bus_addr - RA_BUF;
    buf_hit   = (bus_addr >= RA_BUF) && ({24'd0, buf_off} < BUF_DEPTH);
    done_d    = done_set ? 1'b1 : (clr ? 1'b0 : done_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      timing_q <= '0;
      opcode_q <= '0;
      addr_q   <= '0;
      cs_q     <= '0;
      dummy_q  <= '0;
      dcount_q <= '0;
      op_en_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      if (we_mode)   mode_q   <= bus_wdata[0];
      if (we_timing) timing_q <= bus_wdata[11:0];
      if (we_opcode) opcode_q <= bus_wdata[7:0];
      if (we_addr)   addr_q   <= bus_wdata;
      if (we_opcfg) begin
        cs_q    <= bus_wdata[11 +: CS_W];
        dummy_q <= bus_wdata[3:0];
      end
      if (we_dcount) dcount_q <= bus_wdata[CNT_W-1:0];
      if (we_op)     op_en_q  <= bus_wdata[8:1] & EN_MASK;
      done_q <= done_d;
    end
  end

  // byte buffer: the engine's read-phase write wins over the bus
  for (genvar i = 0; i < BUF_DEPTH; i++) begin : g_buf
    logic bus_we;
    assign bus_we = bus_wr && buf_hit && (buf_off[BUF_AW-1:0] == BUF_AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  buf_q[i] <= '0;
      else if (eng_wr && (eng_idx == BUF_AW'(i)))  buf_q[i] <= eng_data;
      else if (bus_we)                             buf_q[i] <= bus_wdata[7:0];
    end
  end

  assign buf_rd_data = buf_q[buf_rd_idx];
  assign done        = done_q;

  // a starting write hands its own enables straight to the engine
  always_comb begin
    en_src       = start ? (bus_wdata[8:1] & EN_MASK) : op_en_q;
    cfg.opcode   = opcode_q;
    cfg.addr     = addr_q;
    cfg.addr4    = mode_q;
    cfg.dummy_n  = dummy_q;
    cfg.dcount   = dcount_q;
    cfg.cs_sel   = 4'(cs_q);
    cfg.en_op    = en_src[6];
    cfg.en_addr  = en_src[5];
    cfg.en_dummy = en_src[7];
    cfg.en_wr    = en_src[4];
    cfg.en_rd    = en_src[1] | en_src[0];
    cfg.t_hold   = timing_q[11:8];
    cfg.t_setup  = timing_q[7:4];
    cfg.t_desel  = timing_q[3:0];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_MODE:   bus_rdata[0]       = mode_q;
      RA_TIMING: bus_rdata[11:0]    = timing_q;
      RA_STATUS: bus_rdata[0]       = done_q;
      RA_OPCODE: bus_rdata[7:0]     = opcode_q;
      RA_ADDR:   bus_rdata          = addr_q;
      RA_OPCFG: begin
        bus_rdata[11 +: CS_W] = cs_q;
        bus_rdata[3:0]        = dummy_q;
      end
      RA_DCOUNT: bus_rdata[CNT_W-1:0] = dcount_q;
      RA_OP:     bus_rdata[8:0]       = {op_en_q, busy};
      default:   if (buf_hit) bus_rdata[7:0] = buf_q[buf_off[BUF_AW-1:0]];
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:12], bus_wdata[10:9]};

  a_r13_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == RA_OP) && busy) |=> $stable(op_en_q));
  a_r12_clear_drops_done: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !done_set) |=> !done_q);
  a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr) |=> done_q);

endmodule

// File: rtl/spi_flash_seq_engine.sv
module spi_flash_seq_engine
  import spi_flash_seq_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int BUF_AW = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_cfg_t           cfg,
  output logic              busy,
  output logic              done_set,
  output logic [BUF_AW-1:0] buf_idx,
  input  logic [7:0]        buf_data,
  output logic              wr_en,
  output logic [BUF_AW-1:0] wr_idx,
  output logic [7:0]        wr_data,
  output logic [NUM_CS-1:0] cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);

  seq_state_e       st_q, st_d;
  op_cfg_t          cfg_q, cfg_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [2:0]       ph_q, ph_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [2:0]       bit_q, bit_d;
  logic             half_q, half_d;
  logic [7:0]       sreg_q, sreg_d;
  logic [7:0]       rx_q, rx_d;

  logic [2:0]       ld_ph;
  logic [CNT_W-1:0] ld_idx;
  logic [7:0]       ld_byte;
  logic             more_in_ph;

  function automatic logic [CNT_W-1:0] ph_len(input logic [2:0] ph, input op_cfg_t c);
    case (ph)
      PH_OP:    ph_len = c.en_op ? CNT_W'(1) : '0;
      PH_ADDR:  ph_len = c.en_addr ? (c.addr4 ? CNT_W'(4) : CNT_W'(3)) : '0;
      PH_DUMMY: ph_len = c.en_dummy ? CNT_W'(c.dummy_n) : '0;
      PH_WR:    ph_len = c.en_wr ? c.dcount : '0;
      PH_RD:    ph_len = c.en_rd ? c.dcount : '0;
      default:  ph_len = '0;
    endcase
  endfunction

  // first phase at or after 'from' that has bytes to send
  function automatic logic [2:0] first_ph(input logic [2:0] from, input op_cfg_t c);
    logic found;
    first_ph = PH_END;
    found    = 1'b0;
    for (int p = 0; p < 5; p++) begin
      if (!found && (3'(p) >= from) && (ph_len(3'(p), c) != '0)) begin
        first_ph = 3'(p);
        found    = 1'b1;
      end
    end
  endfunction

  function automatic logic [7:0] byte_of(input logic [2:0] ph, input logic [CNT_W-1:0] idx,
                                         input op_cfg_t c, input logic [7:0] bufb);
    logic [1:0] pos;
    pos = (c.addr4 ? 2'd3 : 2'd2) - idx[1:0];
    case (ph)
      PH_OP:   byte_of = c.opcode;
      PH_ADDR: byte_of = c.addr[{pos, 3'b000} +: 8];
      PH_WR:   byte_of = bufb;
      default: byte_of = 8'h00;
    endcase
  endfunction

  // which byte gets loaded next into the shifter
  always_comb begin
    more_in_ph = ({1'b0, idx_q} + 15'd1) < {1'b0, ph_len(ph_q, cfg_q)};
    if (st_q == ST_SETUP) begin
      ld_ph  = first_ph(PH_OP, cfg_q);
      ld_idx = '0;
    end else if (more_in_ph) begin
      ld_ph  = ph_q;
      ld_idx = idx_q + CNT_W'(1);
    end else begin
      ld_ph  = first_ph(ph_q + 3'd1, cfg_q);
      ld_idx = '0;
    end
    buf_idx = ld_idx[BUF_AW-1:0];
    ld_byte = byte_of(ld_ph, ld_idx, cfg_q, buf_data);
  end

  always_comb begin
    st_d = st_q;  cfg_d = cfg_q;  cnt_d = cnt_q;  ph_d = ph_q;  idx_d = idx_q;
    bit_d = bit_q;  half_d = half_q;  sreg_d = sreg_q;  rx_d = rx_q;
    done_set = 1'b0;
    wr_en    = 1'b0;
    wr_idx   = idx_q[BUF_AW-1:0];
    wr_data  = rx_q;
    case (st_q)
      ST_IDLE: if (start) begin
        cfg_d = cfg;
        cnt_d = cfg.t_setup;
        st_d  = ST_SETUP;
      end
      ST_SETUP: begin
        if (cnt_q != '0) cnt_d = cnt_q - 4'd1;
        else if (ld_ph == PH_END) begin
          st_d  = ST_HOLD;
          cnt_d = cfg_q.t_hold;
        end else begin
          st_d = ST_SHIFT;  ph_d = ld_ph;  idx_d = ld_idx;
          bit_d = '0;  half_d = 1'b0;  sreg_d = ld_byte;
        end
      end
      ST_SHIFT: begin
        if (!half_q) begin
          half_d = 1'b1;
          rx_d   = {rx_q[6:0], miso};   // sampled as the serial clock rises
        end else begin
          half_d = 1'b0;
          bit_d  = bit_q + 3'd1;
          sreg_d = {sreg_q[6:0], 1'b0};
          if (bit_q == 3'd7) begin
            wr_en = (ph_q == PH_RD);
            if (ld_ph == PH_END) begin
              st_d  = ST_HOLD;
              cnt_d = cfg_q.t_hold;
            end else begin
              ph_d = ld_ph;  idx_d = ld_idx;  sreg_d = ld_byte;
            end
          end
        end
      end
      ST_HOLD: begin
        if (cnt_q != '0) cnt_d = cnt_q - 4'd1;
        else begin
          st_d  = ST_DESEL;
          cnt_d = cfg_q.t_desel;
        end
      end
      ST_DESEL: begin
        if (cnt_q != '0) cnt_d = cnt_q - 4'd1;
        else begin
          st_d     = ST_IDLE;
          done_set = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cfg_q <= '0;  cnt_q <= '0;  ph_q <= PH_OP;  idx_q <= '0;
      bit_q <= '0;  half_q <= 1'b0;  sreg_q <= '0;  rx_q <= '0;
    end else begin
      st_q <= st_d;  cfg_q <= cfg_d;  cnt_q <= cnt_d;  ph_q <= ph_d;  idx_q <= idx_d;
      bit_q <= bit_d;  half_q <= half_d;  sreg_q <= sreg_d;  rx_q <= rx_d;
    end
  end

  logic in_frame;
  assign in_frame = (st_q == ST_SETUP) || (st_q == ST_SHIFT) || (st_q == ST_HOLD);
  assign busy     = (st_q != ST_IDLE);
  assign sclk     = (st_q == ST_SHIFT) && half_q;
  assign mosi     = sreg_q[7];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(in_frame && (cfg_q.cs_sel[CS_W-1:0] == CS_W'(i)));
  end

  logic unused_cfg;
  assign unused_cfg = ^{cfg_q.cs_sel, idx_q};

  a_r8_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r3_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  a_r3_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (cs_n != '1));
  a_r13_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_flash_seq_pkg::*;
#(
  parameter int NUM_CS    = 2,
  parameter int BUF_DEPTH = 16,
  localparam int BUF_AW   = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              op_done,
  output logic [NUM_CS-1:0] flash_cs_n,
  output logic              flash_sclk,
  output logic              flash_mosi,
  input  logic              flash_miso
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  op_cfg_t           cfg;
  logic              start, busy, done_set;
  logic [BUF_AW-1:0] buf_idx, wr_idx;
  logic [7:0]        buf_data, wr_data;
  logic              wr_en;

  spi_flash_seq_regs #(.NUM_CS(NUM_CS), .BUF_DEPTH(BUF_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .start(start), .cfg(cfg), .busy(busy), .done_set(done_set), .done(op_done),
    .buf_rd_idx(buf_idx), .buf_rd_data(buf_data),
    .eng_wr(wr_en), .eng_idx(wr_idx), .eng_data(wr_data)
  );

  spi_flash_seq_engine #(.NUM_CS(NUM_CS), .BUF_AW(BUF_AW)) u_eng (
    .clk(clk), .rst_n(rst_int_n),
    .start(start), .cfg(cfg), .busy(busy), .done_set(done_set),
    .buf_idx(buf_idx), .buf_data(buf_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cs_n(flash_cs_n), .sclk(flash_sclk), .mosi(flash_mosi), .miso(flash_miso)
  );

endmodule

// File: tb/spi_flash_seq_tb.sv
module spi_flash_seq_tb;

  localparam logic [7:0] RA_MODE = 8'h00, RA_TIMING = 8'h01, RA_STATUS = 8'h02,
                         RA_CLEAR = 8'h03, RA_OPCODE = 8'h04, RA_ADDR = 8'h05,
                         RA_OPCFG = 8'h06, RA_DCOUNT = 8'h07, RA_OP = 8'h08,
                         RA_BUF = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        op_done;
  logic [1:0]  cs_n;
  logic        sclk, mosi, miso;

  always #10 clk = ~clk;   // 50 MHz

  spi_flash_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .op_done(op_done),
    .flash_cs_n(cs_n), .flash_sclk(sclk), .flash_mosi(mosi), .flash_miso(miso)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int p);
    return 8'h3C ^ 8'(p * 29);
  endfunction

  // ---------------- flash model + scoreboard monitor ----------------
  logic [7:0] exp_q[$];
  int   n_fall = 0, bitn = 0, setup_cnt = 0, hold_cnt = 0, desel_cnt = 0;
  int   meas_setup = -1, meas_hold = -1;
  logic [1:0] cs_seen = 2'b11;
  logic prev_sclk = 1'b0, prev_low = 1'b0, seen_rise = 1'b0;
  logic [7:0] rx_byte = 8'h00;

  always_comb begin
    logic [7:0] b;
    b    = pat(n_fall >> 3);
    miso = b[3'd7 - 3'(n_fall)];
  end

  always @(negedge clk) begin
    logic low;
    low = (cs_n != 2'b11);
    if (!low) begin
      n_fall <= 0;  bitn <= 0;  setup_cnt <= 0;  seen_rise <= 1'b0;
      if (!op_done) desel_cnt <= desel_cnt + 1;
      if (prev_low) meas_hold <= hold_cnt;
    end else begin
      desel_cnt <= 0;
      cs_seen   <= cs_n;
      if (prev_sclk && !sclk) n_fall <= n_fall + 1;
      if (!sclk && !seen_rise) setup_cnt <= setup_cnt + 1;
      if (sclk) hold_cnt <= 0;
      else if (seen_rise) hold_cnt <= hold_cnt + 1;
      if (sclk && !prev_sclk) begin
        if (!seen_rise) meas_setup <= setup_cnt;
        seen_rise <= 1'b1;
        if (bitn == 7) begin
          logic [7:0] got;
          got  = {rx_byte[6:0], mosi};
          bitn <= 0;
          if (exp_q.size() == 0) chk(1'b0, "R2 unexpected byte", got, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(got == e, "R2/R3 stream byte", got, e);
          end
        end else bitn <= bitn + 1;
        rx_byte <= {rx_byte[6:0], mosi};
      end
    end
    prev_sclk <= sclk;
    prev_low  <= low;
  end

  // ---------------- driver tasks ----------------
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1;  bus_addr = a;  bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  task automatic wait_done();
    while (!op_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input logic [31:0] opw);
    bus_write(RA_OP, opw);
    wait_done();
    chk(exp_q.size() == 0, "R2 all expected bytes sent", exp_q.size(), 0);
  endtask

  task automatic clear_done();
    bus_write(RA_CLEAR, 32'h1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL watchdog timeout actual=%0d expected=<%0d", cyc, 100000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cs_n == 2'b11, "R1 chip selects idle", cs_n, 3);
    chk(sclk == 1'b0, "R1 sclk idle", sclk, 0);
    chk(op_done == 1'b0, "R1 done low", op_done, 0);
    bus_read(RA_STATUS, rd);
    chk(rd == 0, "R1 status reads zero", rd, 0);

    // opcode only, setup 2 hold 3 deselect 4
    bus_write(RA_TIMING, 32'h0000_0324);
    bus_write(RA_OPCODE, 32'h9F);
    bus_write(RA_OPCFG, 32'h0);
    push(8'h9F);
    run_op(32'h81);
    chk(meas_setup == 4, "R9 setup cycles", meas_setup, 4);
    chk(meas_hold == 4, "R10 hold cycles", meas_hold, 4);
    chk(desel_cnt == 5, "R11 deselect cycles", desel_cnt, 5);
    chk(cs_seen == 2'b10, "R8 cs0 selected", cs_seen, 2);
    repeat (5) @(negedge clk);
    chk(op_done == 1'b1, "R12 done sticky", op_done, 1);
    bus_write(RA_CLEAR, 32'h0);
    chk(op_done == 1'b1, "R12 clear with bit0=0 keeps done", op_done, 1);
    bus_read(RA_STATUS, rd);
    chk(rd[0] == 1'b1, "R12 status bit0 set", rd, 1);
    clear_done();
    chk(op_done == 1'b0, "R12 clear drops done", op_done, 0);

    // write: opcode, 3-byte addr, dummy enabled with zero count, 3 data bytes, cs1
    bus_write(RA_TIMING, 32'h0);
    bus_write(RA_MODE, 32'h0);
    bus_write(RA_OPCODE, 32'h02);
    bus_write(RA_ADDR, 32'h7712_3456);
    bus_write(RA_OPCFG, 32'h0000_0800);
    bus_write(RA_DCOUNT, 32'd3);
    bus_write(RA_BUF + 8'd0, 32'h11);
    bus_write(RA_BUF + 8'd1, 32'h22);
    bus_write(RA_BUF + 8'd2, 32'h33);
    foreach (exp_q[i]) exp_q.delete();
    push(8'h02); push(8'h12); push(8'h34); push(8'h56);   // R4 3-byte address
    push(8'h11); push(8'h22); push(8'h33);                // R6 buffer data
    run_op(32'h1E1);
    chk(cs_seen == 2'b01, "R8 cs1 selected", cs_seen, 1);
    chk(meas_setup == 2, "R9 zero setup", meas_setup, 2);
    chk(meas_hold == 1, "R10 zero hold", meas_hold, 1);
    chk(desel_cnt == 1, "R11 zero deselect", desel_cnt, 1);
    clear_done();

    // read: opcode, 4-byte address, 2 dummy bytes, 4 read bytes
    bus_write(RA_MODE, 32'h1);
    bus_write(RA_OPCODE, 32'h0B);
    bus_write(RA_ADDR, 32'hA1B2_C3D4);
    bus_write(RA_OPCFG, 32'h2);
    bus_write(RA_DCOUNT, 32'd4);
    push(8'h0B); push(8'hA1); push(8'hB2); push(8'hC3); push(8'hD4);  // R4 4-byte
    push(8'h00); push(8'h00);                                          // R5 dummy
    for (int k = 0; k < 4; k++) push(8'h00);                          // R7 idle out
    run_op(32'h1C5);
    for (int k = 0; k < 4; k++) begin
      bus_read(RA_BUF + 8'(k), rd);
      chk(rd[7:0] == pat(7 + k), "R7 read byte stored", rd[7:0], pat(7 + k));
    end
    clear_done();

    // address only; dummy count set but disabled; start while busy is ignored
    bus_write(RA_MODE, 32'h0);
    bus_write(RA_ADDR, 32'h000A_0B0C);
    bus_write(RA_OPCFG, 32'h3);
    push(8'h0A); push(8'h0B); push(8'h0C);
    bus_write(RA_OP, 32'h41);
    repeat (8) @(negedge clk);
    bus_read(RA_OP, rd);
    chk(rd[0] == 1'b1, "R13 start reads 1 while running", rd[0], 1);
    bus_write(RA_OP, 32'h81);
    wait_done();
    chk(exp_q.size() == 0, "R2 skipped phases", exp_q.size(), 0);
    bus_read(RA_OP, rd);
    chk(rd == 32'h40, "R13 self-clear, busy write ignored", rd, 32'h40);
    clear_done();
    repeat (40) @(negedge clk);
    chk(cs_n == 2'b11 && op_done == 1'b0, "R13 no second operation", {op_done, cs_n}, 3);

    // read-status enable (bit 1)
    bus_write(RA_OPCODE, 32'h05);
    bus_write(RA_OPCFG, 32'h0);
    bus_write(RA_DCOUNT, 32'd2);
    push(8'h05); push(8'h00); push(8'h00);
    run_op(32'h83);
    bus_read(RA_BUF, rd);
    chk(rd[7:0] == pat(1), "R7 status byte 0", rd[7:0], pat(1));
    bus_read(RA_BUF + 8'd1, rd);
    chk(rd[7:0] == pat(2), "R7 status byte 1", rd[7:0], pat(2));
    chk(sclk == 1'b0, "R3 clock idles low", sclk, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule